// File: doc/BRIEF.md
# Register-memory move instruction unit

This block executes a family of 16-bit data-movement instructions against an internal file of sixteen 32-bit registers. One instruction is presented per cycle with a valid strobe. The block decodes it and drives a single memory port in the same cycle. On the next clock edge it writes back up to two registers: the data register and, for the auto-modifying forms, the pointer register.

Seven forms are supported:

- register copy;
- store or load through a register pointer;
- store with a pre-decremented pointer;
- load with a post-incremented pointer;
- store or load at R0 plus a register.

Every memory form exists in byte, word and longword sizes. Narrow loads are sign-extended into the destination register. Any other encoding is flagged as illegal and changes nothing.

The memory port is single-cycle. Address, size, write data and the strobes are combinational from the instruction and the register file. A write is taken by the memory on the clock edge, and read data must be returned within the same cycle. Data on the port is right-justified: the byte at the lowest address of a multi-byte access sits in bits 7:0.

Top module: `mov_unit`

## Requirements
- R1: Encoding high nibble 0110 and low nibble 0011 copies register m (bits 7:4) into register n (bits 11:8). It makes no memory access.
- R2: High nibble 0010 with low nibble 0000/0001/0010 stores register m at the address held in register n. mem_size is 0 for byte, 1 for word and 2 for long. mem_wdata carries the low 8, 16 or 32 bits of register m, with zeros above.
- R3: High nibble 0110 with low nibble 0000/0001/0010 loads from the address in register m into register n. Byte and word data are sign-extended from bit 7 or bit 15, and mem_rdata bits above the access size are ignored.
- R4: High nibble 0010 with low nibble 0100/0101/0110 first lowers register n by 1, 2 or 4, then stores register m at the lowered address. When m equals n, the value stored is the one from before the decrement.
- R5: High nibble 0110 with low nibble 0100/0101/0110 loads from the address in register m into register n, then raises register m by 1, 2 or 4. When m equals n, the loaded value is kept and the increment is lost.
- R6: High nibble 0000 with low nibble 0100/0101/0110 stores register m at R0 plus register n. Low nibble 1100/1101/1110 loads register n from R0 plus register m.
- R7: For each valid legal instruction, done is high for exactly the one cycle that follows it.
- R8: Any other encoding presented with insn_valid raises illegal for the following cycle. It makes no memory access and leaves every register unchanged.
- R9: After reset all sixteen registers read as zero and both done and illegal are low.
- R10: While insn_valid is low, no memory access takes place and no register changes.
- R11: mem_re is high only for the load forms, mem_we only for the store forms, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction present this cycle |
| insn | input | 16 | Instruction word |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Access size: 0 byte, 1 word, 2 long |
| mem_wdata | output | 32 | Right-justified store data |
| mem_we | output | 1 | Write strobe, taken on the clock edge |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 32 | Right-justified read data, same cycle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle undecoded-encoding pulse |

## Verification
The bound assertions check the cycle-level port rules on every clock:

- read and write strobes exclusive, and both silent while idle;
- no access size of 3;
- store data zero above its size;
- done following every access, and done and illegal exclusive;
- an illegal pulse only after a cycle with no memory traffic.

Register contents, and therefore sign extension, the size-scaled pointer updates and the priority rules when m equals n, are only visible through later accesses. These are shown by the bench's behavioural model of the register file and memory, including final dumps of every register through stores.

// File: rtl/mov_pkg.sv
package mov_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);
    localparam int INSN_W = 16;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_L = 2'd2,
        SZ_X = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_COPY,
        OP_ST_PTR,
        OP_LD_PTR,
        OP_ST_DEC,
        OP_LD_INC,
        OP_ST_IDX,
        OP_LD_IDX
    } op_e;

    typedef struct packed {
        op_e                op;
        size_e              sz;
        logic [RIDX_W-1:0]  rn;
        logic [RIDX_W-1:0]  rm;
        logic               bad;
    } dec_t;

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
        logic                      done;
        logic                      illegal;
    } state_t;
endpackage

// File: rtl/mov_decode.sv
module mov_decode
    import mov_pkg::*;
(
    input  logic              valid,
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [3:0] hi;
    logic [3:0] lo;
    logic       sz_ok;

    always_comb begin
        hi     = insn[15:12];
        lo     = insn[3:0];
        sz_ok  = (lo[1:0] != 2'b11);
        dec    = '0;
        dec.rn = insn[11:8];
        dec.rm = insn[7:4];
        dec.sz = size_e'(lo[1:0]);
        dec.op = OP_NONE;
        case (hi)
            4'b0110: begin
                if (lo == 4'b0011)                  dec.op = OP_COPY;
                else if (lo[3:2] == 2'b00 && sz_ok) dec.op = OP_LD_PTR;
                else if (lo[3:2] == 2'b01 && sz_ok) dec.op = OP_LD_INC;
            end
            4'b0010: begin
                if (lo[3:2] == 2'b00 && sz_ok)      dec.op = OP_ST_PTR;
                else if (lo[3:2] == 2'b01 && sz_ok) dec.op = OP_ST_DEC;
            end
            4'b0000: begin
                if (lo[3:2] == 2'b01 && sz_ok)      dec.op = OP_ST_IDX;
                else if (lo[3:2] == 2'b11 && sz_ok) dec.op = OP_LD_IDX;
            end
            default: dec.op = OP_NONE;
        endcase
        if (!valid) begin
            dec.op = OP_NONE;
        end
        dec.bad = valid && (dec.op == OP_NONE);
    end
endmodule

// File: rtl/mov_lane.sv
module mov_lane
    import mov_pkg::*;
(
    input  size_e            sz,
    input  logic [XLEN-1:0]  rdata,
    input  logic [XLEN-1:0]  src,
    output logic [XLEN-1:0]  ld_val,
    output logic [XLEN-1:0]  st_val,
    output logic [XLEN-1:0]  step
);
    always_comb begin
        case (sz)
            SZ_B: begin
                ld_val = {{(XLEN-8){rdata[7]}}, rdata[7:0]};
                st_val = {{(XLEN-8){1'b0}}, src[7:0]};
                step   = XLEN'(1);
            end
            SZ_W: begin
                ld_val = {{(XLEN-16){rdata[15]}}, rdata[15:0]};
                st_val = {{(XLEN-16){1'b0}}, src[15:0]};
                step   = XLEN'(2);
            end
            default: begin
                ld_val = rdata;
                st_val = src;
                step   = XLEN'(4);
            end
        endcase
    end
endmodule

// File: rtl/mov_unit.sv
module mov_unit
    import mov_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        insn_valid,
    input  logic [15:0] insn,
    output logic [31:0] mem_addr,
    output logic [1:0]  mem_size,
    output logic [31:0] mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic        illegal
);
    dec_t            dec;
    state_t          st_d;
    state_t          st_q;
    logic [XLEN-1:0] val_m;
    logic [XLEN-1:0] val_n;
    logic [XLEN-1:0] val_r0;
    logic [XLEN-1:0] ld_val;
    logic [XLEN-1:0] st_val;
    logic [XLEN-1:0] step;

    mov_decode u_dec (
        .valid (insn_valid),
        .insn  (insn),
        .dec   (dec)
    );

    assign val_m  = st_q.regs[dec.rm];
    assign val_n  = st_q.regs[dec.rn];
    assign val_r0 = st_q.regs[0];

    mov_lane u_lane (
        .sz     (dec.sz),
        .rdata  (mem_rdata),
        .src    (val_m),
        .ld_val (ld_val),
        .st_val (st_val),
        .step   (step)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = (dec.op != OP_NONE);
        st_d.illegal = dec.bad;
        mem_addr     = '0;
        mem_size     = 2'b00;
        mem_wdata    = '0;
        mem_we       = 1'b0;
        mem_re       = 1'b0;
        case (dec.op)
            OP_COPY: begin
                st_d.regs[dec.rn] = val_m;
            end
            OP_ST_PTR: begin
                mem_addr  = val_n;
                mem_size  = dec.sz;
                mem_wdata = st_val;
                mem_we    = 1'b1;
            end
            OP_LD_PTR: begin
                mem_addr          = val_m;
                mem_size          = dec.sz;
                mem_re            = 1'b1;
                st_d.regs[dec.rn] = ld_val;
            end
            OP_ST_DEC: begin
                mem_addr          = val_n - step;
                mem_size          = dec.sz;
                mem_wdata         = st_val;
                mem_we            = 1'b1;
                st_d.regs[dec.rn] = val_n - step;
            end
            OP_LD_INC: begin
                mem_addr          = val_m;
                mem_size          = dec.sz;
                mem_re            = 1'b1;
                st_d.regs[dec.rm] = val_m + step;
                st_d.regs[dec.rn] = ld_val;
            end
            OP_ST_IDX: begin
                mem_addr  = val_r0 + val_n;
                mem_size  = dec.sz;
                mem_wdata = st_val;
                mem_we    = 1'b1;
            end
            OP_LD_IDX: begin
                mem_addr          = val_r0 + val_m;
                mem_size          = dec.sz;
                mem_re            = 1'b1;
                st_d.regs[dec.rn] = ld_val;
            end
            default: begin
                mem_we = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign illegal = st_q.illegal;
endmodule

// File: rtl/mov_unit_chk.sv
module mov_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_valid,
    input logic [1:0]  mem_size,
    input logic [31:0] mem_wdata,
    input logic        mem_we,
    input logic        mem_re,
    input logic        done,
    input logic        illegal
);
    p_rw_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |-> (!mem_we && !mem_re));

    p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_size != 2'b11));

    p_byte_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_size == 2'b00) |-> (mem_wdata[31:8] == 24'd0));

    p_word_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_size == 2'b01) |-> (mem_wdata[31:16] == 16'd0));

    p_access_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && (mem_we || mem_re)) |=> done);

    p_done_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(insn_valid));

    p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));

    p_ill_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(insn_valid && !mem_we && !mem_re));
endmodule

bind mov_unit mov_unit_chk u_chk (.*);

// File: tb/mov_unit_bench.sv
module mov_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [15:0] insn = '0;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic        illegal;

    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] m_reg [16];
    logic [7:0]  m_mem [256];
    logic        e_done = 1'b0;
    logic        e_ill  = 1'b0;

    always #4 clk = ~clk;

    mov_unit u_mov_unit (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .done(done), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // form codes: 0 none, 1 copy, 2 st ptr, 3 ld ptr, 4 st dec, 5 ld inc, 6 st idx, 7 ld idx
    function automatic int form_of(input logic [15:0] w);
        logic [3:0] h = w[15:12];
        logic [3:0] l = w[3:0];
        if (h == 4'h6 && l == 4'h3) return 1;
        if (l[1:0] == 2'b11) return 0;
        if (h == 4'h2 && l[3:2] == 2'b00) return 2;
        if (h == 4'h6 && l[3:2] == 2'b00) return 3;
        if (h == 4'h2 && l[3:2] == 2'b01) return 4;
        if (h == 4'h6 && l[3:2] == 2'b01) return 5;
        if (h == 4'h0 && l[3:2] == 2'b01) return 6;
        if (h == 4'h0 && l[3:2] == 2'b11) return 7;
        return 0;
    endfunction

    task automatic step(input logic [15:0] w, input bit v);
        int          f;
        int          nb;
        int          n;
        int          m;
        logic [31:0] a;
        logic [31:0] rv;
        logic [31:0] sv;
        logic [31:0] lv;
        string       tg;
        @(negedge clk);
        chk(done === e_done, "R7 done", 32'(done), 32'(e_done));
        chk(illegal === e_ill, "R8 illegal", 32'(illegal), 32'(e_ill));
        insn = w;
        insn_valid = v;
        mem_rdata = '0;
        f  = v ? form_of(w) : 0;
        n  = int'(w[11:8]);
        m  = int'(w[7:4]);
        nb = (w[1:0] == 2'b00) ? 1 : (w[1:0] == 2'b01) ? 2 : 4;
        #1;
        case (f)
            2: a = m_reg[n];
            3, 5: a = m_reg[m];
            4: a = m_reg[n] - 32'(nb);
            6: a = m_reg[0] + m_reg[n];
            7: a = m_reg[0] + m_reg[m];
            default: a = '0;
        endcase
        case (f)
            2: tg = "R2"; 3: tg = "R3"; 4: tg = "R4";
            5: tg = "R5"; 6, 7: tg = "R6"; 1: tg = "R1";
            default: tg = v ? "R8" : "R10";
        endcase
        rv = 32'hC3C3C3C3;
        for (int k = 0; k < nb; k++) rv[8*k +: 8] = m_mem[8'(a + 32'(k))];
        mem_rdata = rv;
        #1;
        chk(mem_we === (f == 2 || f == 4 || f == 6), {tg, " we R11"}, 32'(mem_we), 32'(f == 2 || f == 4 || f == 6));
        chk(mem_re === (f == 3 || f == 5 || f == 7), {tg, " re R11"}, 32'(mem_re), 32'(f == 3 || f == 5 || f == 7));
        if (f >= 2) begin
            chk(mem_addr === a, {tg, " addr"}, mem_addr, a);
            chk(mem_size === w[1:0], {tg, " size"}, 32'(mem_size), 32'(w[1:0]));
        end
        sv = m_reg[m];
        if (nb == 1) sv = {24'd0, sv[7:0]};
        if (nb == 2) sv = {16'd0, sv[15:0]};
        if (f == 2 || f == 4 || f == 6)
            chk(mem_wdata === sv, {tg, " wdata"}, mem_wdata, sv);
        lv = rv;
        if (nb == 1) lv = {{24{rv[7]}}, rv[7:0]};
        if (nb == 2) lv = {{16{rv[15]}}, rv[15:0]};
        case (f)
            1: m_reg[n] = m_reg[m];
            3, 7: m_reg[n] = lv;
            4: m_reg[n] = a;
            5: begin m_reg[m] = m_reg[m] + 32'(nb); m_reg[n] = lv; end
            default: ;
        endcase
        if (f == 2 || f == 4 || f == 6)
            for (int k = 0; k < nb; k++) m_mem[8'(a + 32'(k))] = sv[8*k +: 8];
        e_done = (f != 0);
        e_ill  = v && (f == 0);
    endtask

    // Long store of every register at @R0 (R0 itself included) to expose the file.
    task automatic dump();
        for (int r = 0; r < 16; r++) step({4'h2, 4'h0, 4'(r), 4'h2}, 1'b1);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog act=%0d exp=%0d", n_chk, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = 8'(i * 37 + 11);
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(done === 1'b0, "R9 done", 32'(done), 0);
        chk(illegal === 1'b0, "R9 illegal", 32'(illegal), 0);
        rst_n = 1'b1;
        // R9: zeros from the register file
        dump();
        // R5: fill R1..R15 with long post-increment loads through R0
        for (int r = 1; r < 16; r++) step({4'h6, 4'(r), 4'h0, 4'h6}, 1'b1);
        // R5: byte and word post-increment loads, including m==n
        for (int s = 0; s < 3; s++) begin
            step({4'h6, 4'h3, 4'h0, 4'(4 + s)}, 1'b1);
            step({4'h6, 4'h7, 4'h7, 4'(4 + s)}, 1'b1);
        end
        // R3: loads through pointer in each size
        for (int s = 0; s < 3; s++) step({4'h6, 4'(5 + s), 4'(2 + s), 4'(s)}, 1'b1);
        // R2: stores through pointer
        for (int s = 0; s < 3; s++) step({4'h2, 4'(9 + s), 4'(4 + s), 4'(s)}, 1'b1);
        // R4: pre-decrement stores, including m==n
        for (int s = 0; s < 3; s++) begin
            step({4'h2, 4'h8, 4'h1, 4'(4 + s)}, 1'b1);
            step({4'h2, 4'hA, 4'hA, 4'(4 + s)}, 1'b1);
        end
        // R6: indexed store and load
        for (int s = 0; s < 3; s++) begin
            step({4'h0, 4'(2 + s), 4'(12 - s), 4'(4 + s)}, 1'b1);
            step({4'h0, 4'(13 - s), 4'(6 + s), 4'(12 + s)}, 1'b1);
        end
        // R1: copies
        step({4'h6, 4'h4, 4'hE, 4'h3}, 1'b1);
        step({4'h6, 4'h0, 4'h9, 4'h3}, 1'b1);
        dump();
        // R8: undecoded encodings, back to back
        step(16'h2453, 1'b1);
        step(16'h6127, 1'b1);
        step(16'h0348, 1'b1);
        step(16'h0567, 1'b1);
        step(16'hF000, 1'b1);
        step(16'h6A3F, 1'b1);
        // R10: legal stores and loads with valid low
        step(16'h6126, 1'b0);
        step(16'h2346, 1'b0);
        step(16'h6563, 1'b0);
        // R7: legal after idle, then idle
        step(16'h6222, 1'b1);
        step(16'h0000, 1'b0);
        dump();
        step(16'h0000, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule